// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block is an on-chip synchronous memory whose command bus can carry a read or a write on every enabled clock, in any order, with no idle cycle between a read and a following write. The trick is a fixed two-clock offset between a command and its data. A write's address and byte enables are held in a two-deep command pipeline. Its data is taken from the write-data bus on the second enabled clock after the command. A read's result is driven during the same slot, so the data bus never needs a turnaround cycle.

The array is updated late, so a read can target a word whose write has not yet been committed. A forwarding path merges the write data arriving in that cycle into the read result, lane by lane. A two-bit burst counter lets the controller issue one external address and then continue for up to four words. The continuing words follow either a linear or an interleaved order. The tri-state data bus is split into input data, output data and an output-drive flag. A clock-enable input stalls the whole pipeline, and a sleep input puts the outputs in high impedance.

Top module: `zt_sram`

## Requirements
- R1: Read and write commands may be issued on consecutive enabled clocks in any mix. Every enabled clock moves at most one word on the data bus.
- R2: A selected read sampled at enabled edge T loads `rdata_o` at edge T+1. The value is then held for sampling at edge T+2, and `rdata_oe_o` is high in that window when `oe_i` is high.
- R3: A write sampled at enabled edge T takes `wdata_i` at the second enabled edge after T and commits it to the array there.
- R4: A read whose address equals that of the write committing at the edge where the read result is loaded returns the newly arriving bytes for the enabled lanes. It returns array contents for the other lanes.
- R5: With `clk_en_i` low, the edge changes nothing: no write is committed, and the command pipeline, burst state and output register hold.
- R6: With `adv_i` low, a new command and external address are loaded and the burst count restarts at 0. With `adv_i` high, the previous command type repeats with the count incremented modulo 4, and a continue after a deselect stays deselected.
- R7: The burst address keeps the upper address bits of the loaded address. With `mode_i` = 0 its two low bits are (start + count) mod 4. With `mode_i` = 1 they are start XOR count.
- R8: On the enabled edge after a write command, `rdata_oe_o` goes low whatever the level of `oe_i`.
- R9: Byte lane b is `wdata_i[b*BYTE_W +: BYTE_W]` and is written only when `be_i[b]` was high with the command. A write with all enables low leaves the word unchanged.
- R10: The device is selected only when `cs_n_i`=0, `cs_i`=1 and `cs2_n_i`=0. A load while not selected is a no-op: outputs go high impedance after the pipeline delay and the array is untouched.
- R11: While `sleep_i` is high, `rdata_oe_o` is low and new commands are treated as deselects. After `sleep_i` falls, the outputs stay high impedance until a new read completes.
- R12: `rdata_oe_o` follows `oe_i` combinationally while a read result is held.
- R13: After reset the command pipeline is idle and `rdata_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Clock enable; low stalls the edge |
| cs_n_i | input | 1 | Chip select, active low |
| cs_i | input | 1 | Chip select, active high |
| cs2_n_i | input | 1 | Second chip select, active low |
| we_i | input | 1 | 1 = write, 0 = read (on load) |
| adv_i | input | 1 | 1 = continue burst, 0 = load new address |
| addr_i | input | ADDR_W | External word address |
| be_i | input | BYTES | Per-lane write enables, sampled with the command |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_i | input | 1 | Output enable |
| sleep_i | input | 1 | Sleep request |
| wdata_i | input | BYTES*BYTE_W | Write data, two enabled clocks after its command |
| rdata_o | output | BYTES*BYTE_W | Read data |
| rdata_oe_o | output | 1 | Output drive enable for the data bus |

## Verification
The case that matters most is a read sitting one stage behind a write to the same word. At that edge the write commits to the array and the read result is loaded, both at once. The bench provokes it by interleaving reads and writes over a small address range, with random and partial byte enables, and it adds directed write-then-read pairs. The reference model commits the older write before it evaluates the read, in program order. Any missing or wrong per-lane forward therefore shows up as a data mismatch on the following clock. Stalls are mixed into the same traffic, so a forward that fires on a stalled edge is caught as well.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/zt_sram_burst.sv
module zt_sram_burst
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sleep_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic              adv_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTES-1:0]  be_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTES-1:0]  be_o
);
  op_e               op_q, op_n;
  logic [ADDR_W-1:0] base_q, base_n;
  logic [1:0]        cnt_q, cnt_n, lo;

  always_comb begin
    op_n   = op_q;
    base_n = base_q;
    cnt_n  = cnt_q + 2'd1;
    if (sleep_i) begin
      op_n  = OP_IDLE;
      cnt_n = 2'd0;
    end else if (!adv_i) begin
      base_n = addr_i;
      cnt_n  = 2'd0;
      op_n   = sel_i ? (we_i ? OP_WR : OP_RD) : OP_IDLE;
    end
    lo = mode_i ? (base_n[1:0] ^ cnt_n) : (base_n[1:0] + cnt_n);
  end

  assign op_o   = op_n;
  assign addr_o = {base_n[ADDR_W-1:2], lo};
  assign be_o   = be_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en_i) begin
      op_q   <= op_n;
      base_q <= base_n;
      cnt_q  <= cnt_n;
    end
  end

  // R6: a continue keeps the command type and steps the count
  a_r6_continue_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !sleep_i && adv_i && op_q != OP_IDLE)
      |=> (op_q == $past(op_q) && cnt_q == $past(cnt_q) + 2'd1));

  // R10: continuing a deselected burst stays deselected
  a_r10_idle_continue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && adv_i && op_q == OP_IDLE) |=> (op_q == OP_IDLE));
endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [BYTES-1:0]        be_i,
  input  logic [BYTES*BYTE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [BYTES*BYTE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && be_i[b]) lane_mem[waddr_i] <= wdata_i[b*BYTE_W +: BYTE_W];
    end

    assign rdata_o[b*BYTE_W +: BYTE_W] = lane_mem[raddr_i];
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTES  = 2,
  parameter int BYTE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clk_en_i,
  input  logic                    cs_n_i,
  input  logic                    cs_i,
  input  logic                    cs2_n_i,
  input  logic                    we_i,
  input  logic                    adv_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [BYTES-1:0]        be_i,
  input  logic                    mode_i,
  input  logic                    oe_i,
  input  logic                    sleep_i,
  input  logic [BYTES*BYTE_W-1:0] wdata_i,
  output logic [BYTES*BYTE_W-1:0] rdata_o,
  output logic                    rdata_oe_o
);
  localparam int DW = BYTES * BYTE_W;

  op_e               nx_op, s1_op, s2_op;
  logic [ADDR_W-1:0] nx_addr, s1_addr, s2_addr;
  logic [BYTES-1:0]  nx_be, s1_be, s2_be;
  logic [DW-1:0]     arr_rd, fwd_rd, dout_q;
  logic              dout_en_q, sel, fwd_hit, wr_commit;

  assign sel = !cs_n_i && cs_i && !cs2_n_i;

  zt_sram_burst #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (clk_en_i),
    .sleep_i (sleep_i),
    .sel_i   (sel),
    .we_i    (we_i),
    .adv_i   (adv_i),
    .mode_i  (mode_i),
    .addr_i  (addr_i),
    .be_i    (be_i),
    .op_o    (nx_op),
    .addr_o  (nx_addr),
    .be_o    (nx_be)
  );

  // oldest command owns the data bus at this edge
  assign wr_commit = clk_en_i && (s2_op == OP_WR);

  zt_sram_array #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_array (
    .clk_i   (clk_i),
    .we_i    (wr_commit),
    .waddr_i (s2_addr),
    .be_i    (s2_be),
    .wdata_i (wdata_i),
    .raddr_i (s1_addr),
    .rdata_o (arr_rd)
  );

  // coherency: merge the write landing this edge into a read of the same word
  assign fwd_hit = (s2_op == OP_WR) && (s2_addr == s1_addr);

  for (genvar b = 0; b < BYTES; b++) begin : g_fwd
    assign fwd_rd[b*BYTE_W +: BYTE_W] = (fwd_hit && s2_be[b]) ?
      wdata_i[b*BYTE_W +: BYTE_W] : arr_rd[b*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_op     <= OP_IDLE;
      s2_op     <= OP_IDLE;
      s1_addr   <= '0;
      s2_addr   <= '0;
      s1_be     <= '0;
      s2_be     <= '0;
      dout_q    <= '0;
      dout_en_q <= 1'b0;
    end else begin
      if (clk_en_i) begin
        s1_op     <= nx_op;
        s1_addr   <= nx_addr;
        s1_be     <= nx_be;
        s2_op     <= s1_op;
        s2_addr   <= s1_addr;
        s2_be     <= s1_be;
        dout_en_q <= (s1_op == OP_RD);
        if (s1_op == OP_RD) dout_q <= fwd_rd;
      end
      if (sleep_i) dout_en_q <= 1'b0;
    end
  end

  assign rdata_o    = dout_q;
  assign rdata_oe_o = dout_en_q && oe_i && !sleep_i;

  // R4: full-word forward returns the arriving write data
  a_r4_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && !sleep_i && s1_op == OP_RD && s2_op == OP_WR &&
     s1_addr == s2_addr && (&s2_be)) |=> (rdata_o == $past(wdata_i)));

  // R5: a stalled edge holds the output register
  a_r5_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_i && !sleep_i) |=> ($stable(rdata_o) && $stable(dout_en_q)));

  // R8: bus released on the edge after a write command
  a_r8_write_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_i && s1_op == OP_WR) |=> !rdata_oe_o);

  // R11: outputs stay released when sleep ends
  a_r11_wake_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sleep_i) |-> !rdata_oe_o);
endmodule

// File: tb/zt_sram_test.sv
module zt_sram_test;
  localparam int AW = 8;
  localparam int NB = 2;
  localparam int BW = 9;
  localparam int DW = NB * BW;
  localparam logic [2:0] SEL = 3'b010;  // {cs_n, cs, cs2_n}
  localparam logic [2:0] DES = 3'b000;
  localparam logic [NB-1:0] ALL = '1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, clk_en, cs_n, cs, cs2_n, we, adv, mode, oe, sleep;
  logic [AW-1:0] addr;
  logic [NB-1:0] be;
  logic [DW-1:0] wdata, rdata;
  logic rdata_oe;

  zt_sram #(.ADDR_W(AW), .BYTES(NB), .BYTE_W(BW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(clk_en), .cs_n_i(cs_n), .cs_i(cs),
    .cs2_n_i(cs2_n), .we_i(we), .adv_i(adv), .addr_i(addr), .be_i(be),
    .mode_i(mode), .oe_i(oe), .sleep_i(sleep), .wdata_i(wdata),
    .rdata_o(rdata), .rdata_oe_o(rdata_oe)
  );

  typedef struct {
    int            op;  // 0 idle, 1 read, 2 write
    int            addr;
    logic [NB-1:0] be;
    logic [DW-1:0] data;
  } cmd_t;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R13";
  logic [DW-1:0] ref_mem [int];
  bit known [int];
  cmd_t p0 = '{0, 0, '0, '0}, p1 = '{0, 0, '0, '0};
  int b_op = 0, b_base = 0, b_cnt = 0;
  bit exp_en = 0, exp_known = 0;
  logic [DW-1:0] exp_data = '0;

  task automatic chk(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(input bit en, input logic [2:0] csel, input bit w, input bit cont,
                     input int a, input logic [NB-1:0] bmask, input bit md, input bit o, input bit slp);
    cmd_t nc;
    bit s;
    int lo;
    logic [DW-1:0] cur;
    s = (csel == SEL);
    clk_en = en; {cs_n, cs, cs2_n} = csel; we = w; adv = cont;
    addr = AW'(a); be = bmask; mode = md; oe = o; sleep = slp;
    wdata = (p1.op == 2) ? p1.data : DW'($urandom);
    @(posedge clk);
    if (en) begin
      if (p1.op == 2) begin
        cur = ref_mem.exists(p1.addr) ? ref_mem[p1.addr] : '0;
        for (int b = 0; b < NB; b++)
          if (p1.be[b]) cur[b*BW +: BW] = p1.data[b*BW +: BW];
        ref_mem[p1.addr] = cur;
        if (&p1.be) known[p1.addr] = 1;
      end
      exp_en = (p0.op == 1);
      if (exp_en) begin
        exp_known = known.exists(p0.addr);
        if (exp_known) exp_data = ref_mem[p0.addr];
      end
      if (slp) begin
        b_op = 0; b_cnt = 0;
      end else if (!cont) begin
        b_base = a; b_cnt = 0; b_op = s ? (w ? 2 : 1) : 0;
      end else begin
        b_cnt = (b_cnt + 1) % 4;
      end
      lo = md ? ((b_base % 4) ^ b_cnt) : (((b_base % 4) + b_cnt) % 4);
      nc.op = b_op;
      nc.addr = b_base - (b_base % 4) + lo;
      nc.be = bmask;
      nc.data = DW'($urandom);
      p1 = p0;
      p0 = nc;
    end
    if (slp) exp_en = 0;
    @(negedge clk);
    chk(rdata_oe === (exp_en && o && !slp), "drive", DW'(rdata_oe), DW'(exp_en && o && !slp));
    if (exp_en && exp_known) chk(rdata === exp_data, "data", rdata, exp_data);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1, DES, 0, 0, 0, '0, 0, 1, 0);
  endtask

  initial begin
    rst_n = 0; clk_en = 1; {cs_n, cs, cs2_n} = DES; we = 0; adv = 0; addr = '0;
    be = '0; mode = 0; oe = 1; sleep = 0; wdata = '0;
    repeat (3) @(negedge clk);
    tag = "R13";
    chk(rdata_oe === 1'b0, "reset drive", DW'(rdata_oe), '0);
    rst_n = 1;
    @(negedge clk);
    chk(rdata_oe === 1'b0, "post-reset drive", DW'(rdata_oe), '0);

    // R3/R6: fill the array with linear write bursts
    tag = "R3";
    for (int g = 0; g < (1 << AW) / 4; g++) begin
      cyc(1, SEL, 1, 0, g * 4, ALL, 0, 1, 0);
      for (int k = 0; k < 3; k++) cyc(1, SEL, 1, 1, 0, ALL, 0, 1, 0);
    end
    idle(2);

    // R7: read bursts from unaligned starts, both orders
    tag = "R7";
    for (int g = 0; g < 8; g++) begin
      cyc(1, SEL, 0, 0, g * 8 + (g % 4), '0, g % 2, 1, 0);
      for (int k = 0; k < 3; k++) cyc(1, SEL, 0, 1, 0, '0, g % 2, 1, 0);
    end
    tag = "R6";
    cyc(1, SEL, 1, 0, 37, ALL, 1, 1, 0);
    for (int k = 0; k < 5; k++) cyc(1, SEL, 1, 1, 0, ALL, 1, 1, 0);
    cyc(1, SEL, 0, 0, 36, '0, 0, 1, 0);
    for (int k = 0; k < 3; k++) cyc(1, SEL, 0, 1, 0, '0, 0, 1, 0);
    idle(2);

    // R1: free mix of reads and writes on a narrow range
    tag = "R1";
    for (int i = 0; i < 400; i++)
      cyc(1, SEL, 1'($urandom % 2), ($urandom % 4) == 0, $urandom % 8,
          NB'($urandom), 1'($urandom % 2), ($urandom % 4) != 0, 0);
    idle(2);

    // R4: write then read the same word on the next clock
    tag = "R4";
    cyc(1, SEL, 1, 0, 20, ALL, 0, 1, 0);
    cyc(1, SEL, 0, 0, 20, '0, 0, 1, 0);
    cyc(1, SEL, 1, 0, 21, 2'b01, 0, 1, 0);
    cyc(1, SEL, 0, 0, 21, '0, 0, 1, 0);
    cyc(1, SEL, 1, 0, 22, 2'b10, 0, 1, 0);
    cyc(1, SEL, 0, 0, 22, '0, 0, 1, 0);
    idle(3);

    // R5: random stalls over mixed traffic
    tag = "R5";
    for (int i = 0; i < 400; i++)
      cyc(($urandom % 10) < 7, SEL, 1'($urandom % 2), ($urandom % 4) == 0, $urandom % 8,
          NB'($urandom), 0, 1, 0);
    idle(2);

    // R8: write directly after reads with output enable held high
    tag = "R8";
    cyc(1, SEL, 0, 0, 3, '0, 0, 1, 0);
    cyc(1, SEL, 0, 0, 4, '0, 0, 1, 0);
    cyc(1, SEL, 1, 0, 5, ALL, 0, 1, 0);
    cyc(1, SEL, 0, 0, 5, '0, 0, 1, 0);
    idle(3);

    // R9: write with no lanes enabled, then read back
    tag = "R9";
    cyc(1, SEL, 1, 0, 50, '0, 0, 1, 0);
    idle(2);
    cyc(1, SEL, 0, 0, 50, '0, 0, 1, 0);
    idle(3);

    // R10: each chip select alone deselects; continue after deselect
    tag = "R10";
    cyc(1, 3'b110, 1, 0, 60, ALL, 0, 1, 0);
    cyc(1, 3'b000, 1, 0, 61, ALL, 0, 1, 0);
    cyc(1, 3'b011, 0, 0, 62, '0, 0, 1, 0);
    cyc(1, SEL, 1, 1, 0, ALL, 0, 1, 0);
    idle(3);
    cyc(1, SEL, 0, 0, 60, '0, 0, 1, 0);
    cyc(1, SEL, 0, 0, 61, '0, 0, 1, 0);
    idle(3);

    // R11: sleep after deselect, attempted commands ignored
    tag = "R11";
    cyc(1, SEL, 0, 0, 70, '0, 0, 1, 0);
    idle(1);
    for (int i = 0; i < 5; i++) cyc(i % 2, SEL, i % 3 == 0, 0, 70, ALL, 0, 1, 1);
    idle(3);
    cyc(1, SEL, 0, 0, 70, '0, 0, 1, 0);
    idle(3);

    // R12: output enable gates the drive of a held result
    tag = "R12";
    cyc(1, SEL, 0, 0, 9, '0, 0, 0, 0);
    cyc(1, DES, 0, 0, 0, '0, 0, 0, 0);
    cyc(0, DES, 0, 0, 0, '0, 0, 1, 0);
    cyc(0, DES, 0, 0, 0, '0, 0, 0, 0);
    idle(2);

    // R2: isolated read
    tag = "R2";
    cyc(1, SEL, 0, 0, 100, '0, 0, 1, 0);
    idle(3);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog %s: actual timeout expected completion", tag);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule